// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This combinational block expands a compact 13-bit immediate encoding into a 64-bit logical mask. It takes a one-bit width selector, a six-bit run code and a six-bit rotate code. From them it derives an element width of 2, 4, 8, 16, 32 or 64 bits. It then builds one element holding a contiguous run of ones, rotates that run right inside the element, and tiles the element across the full word.

Some combinations of the three fields have no meaning. The block reports these through a valid flag. Whenever the flag is low, the mask output is held at zero. An instruction decoder uses the block next to its datapath: it feeds in the immediate fields and raises an undefined-instruction trap when the valid flag is low.

Top module: `bmask_decoder`

## Requirements
- R1: The element width e comes from the highest set bit of the 7-bit value {wide_i, ~run_code_i}. If wide_i=1, e=64. If wide_i=0, the leading bits of run_code_i select e: prefix 0 gives 32, 10 gives 16, 110 gives 8, 1110 gives 4 and 11110 gives 2.
- R2: With wide_i=0 and run_code_i[5:1]=11111, no element width exists and valid_o is 0.
- R3: Let s = run_code_i & (e-1). When s equals e-1, the encoding is reserved and valid_o is 0. This covers wide_i=1 with run_code_i=63.
- R4: With rot_code_i=0, each element holds s+1 ones in bits 0 through s and zeros in the rest.
- R5: The run is rotated right within its e-bit element by r = rot_code_i & (e-1). Bits that leave bit 0 re-enter at bit e-1.
- R6: Every e-bit slice of mask_o equals the element, so mask_o[j] = mask_o[j mod e].
- R7: When valid_o is 0, mask_o is all zeros.
- R8: When valid_o is 1, mask_o is neither all zeros nor all ones, and it holds exactly (s+1)*(64/e) ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wide_i | input | 1 | Selects a 64-bit element when set |
| run_code_i | input | 6 | Element width prefix and run length minus one |
| rot_code_i | input | 6 | Right rotation amount, reduced modulo the element width |
| mask_o | output | 64 | Replicated bit pattern, zero when invalid |
| valid_o | output | 1 | High when the field combination is allowed |

## Verification
The bench targets the smallest element width, the rotation wrap inside an element, and both kinds of reserved encoding.

- **Two-bit element.** A design that picked the width from the wrong end of the run code would return a 32-bit element where a 2-bit one was meant, and the mask would lose its alternating pattern.
- **Rotation wrap.** A rotation that leaked across element borders, or that used all six rotate bits, would misplace the wrapped ones at the top of each element.
- **Reserved encodings.** A missing reserved check would either report an all-ones mask as valid, or let a mask through with valid low.

Every one of the 8192 input combinations is also compared against a loop-based model.

// File: rtl/bmask_decoder_pkg.sv
package bmask_decoder_pkg;
    localparam int BMD_FIELD_W = 6;
    localparam int BMD_WORD_W  = 1 << BMD_FIELD_W;
    localparam int BMD_LOG_W   = $clog2(BMD_FIELD_W + 1);
endpackage

// File: rtl/bmask_size_find.sv
module bmask_size_find
    import bmask_decoder_pkg::*;
#(
    parameter int FIELD_W = BMD_FIELD_W,
    localparam int LOG_W  = $clog2(FIELD_W + 1)
) (
    input  logic               wide_i,
    input  logic [FIELD_W-1:0] run_code_i,
    output logic [FIELD_W-1:0] lvl_mask_o,
    output logic               size_ok_o
);
    logic [FIELD_W:0] probe;
    logic [LOG_W-1:0] top_pos;

    // Leading-one search over {wide, ~run_code}.
    always_comb begin
        probe   = {wide_i, ~run_code_i};
        top_pos = '0;
        for (int i = 0; i <= FIELD_W; i++) begin
            if (probe[i]) top_pos = LOG_W'(i);
        end
    end

    // Element width minus one, as a mask of low ones.
    always_comb begin
        for (int k = 0; k < FIELD_W; k++) begin
            lvl_mask_o[k] = (k < int'(top_pos));
        end
        size_ok_o = (top_pos != '0);
    end
endmodule

// File: rtl/bmask_element.sv
module bmask_element
    import bmask_decoder_pkg::*;
#(
    parameter int FIELD_W = BMD_FIELD_W,
    localparam int WORD_W = 1 << FIELD_W
) (
    input  logic [FIELD_W-1:0] lvl_mask_i,
    input  logic [FIELD_W-1:0] run_code_i,
    input  logic [FIELD_W-1:0] rot_code_i,
    output logic [WORD_W-1:0]  elem_o,
    output logic               run_ok_o
);
    logic [FIELD_W-1:0] run_len;
    logic [FIELD_W-1:0] rot_amt;
    logic [WORD_W-1:0]  ones;
    logic [FIELD_W-1:0] src;

    always_comb begin
        run_len  = run_code_i & lvl_mask_i;
        rot_amt  = rot_code_i & lvl_mask_i;
        run_ok_o = (run_len != lvl_mask_i);
    end

    // Unrotated run: bits 0..run_len set.
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            ones[i] = (i <= int'(run_len));
        end
    end

    // Right rotation confined to the element.
    always_comb begin
        elem_o = '0;
        src    = '0;
        for (int j = 0; j < WORD_W; j++) begin
            src = (FIELD_W'(j) + rot_amt) & lvl_mask_i;
            if (j <= int'(lvl_mask_i)) elem_o[j] = ones[src];
        end
    end
endmodule

// File: rtl/bmask_replicate.sv
module bmask_replicate
    import bmask_decoder_pkg::*;
#(
    parameter int FIELD_W = BMD_FIELD_W,
    localparam int WORD_W = 1 << FIELD_W
) (
    input  logic [FIELD_W-1:0] lvl_mask_i,
    input  logic [WORD_W-1:0]  elem_i,
    output logic [WORD_W-1:0]  word_o
);
    // Each output bit picks the element bit at its position modulo e.
    for (genvar j = 0; j < WORD_W; j++) begin : g_tile
        assign word_o[j] = elem_i[FIELD_W'(j) & lvl_mask_i];
    end
endmodule

// File: rtl/bmask_decoder.sv
module bmask_decoder
    import bmask_decoder_pkg::*;
#(
    parameter int FIELD_W = BMD_FIELD_W,
    localparam int WORD_W = 1 << FIELD_W
) (
    input  logic               wide_i,
    input  logic [FIELD_W-1:0] run_code_i,
    input  logic [FIELD_W-1:0] rot_code_i,
    output logic [WORD_W-1:0]  mask_o,
    output logic               valid_o
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] mask;
    } result_t;

    logic [FIELD_W-1:0] lvl_mask;
    logic               size_ok;
    logic               run_ok;
    logic [WORD_W-1:0]  elem;
    logic [WORD_W-1:0]  tiled;
    result_t            result_d;

    bmask_size_find #(.FIELD_W(FIELD_W)) u_size (
        .wide_i     (wide_i),
        .run_code_i (run_code_i),
        .lvl_mask_o (lvl_mask),
        .size_ok_o  (size_ok)
    );

    bmask_element #(.FIELD_W(FIELD_W)) u_elem (
        .lvl_mask_i (lvl_mask),
        .run_code_i (run_code_i),
        .rot_code_i (rot_code_i),
        .elem_o     (elem),
        .run_ok_o   (run_ok)
    );

    bmask_replicate #(.FIELD_W(FIELD_W)) u_rep (
        .lvl_mask_i (lvl_mask),
        .elem_i     (elem),
        .word_o     (tiled)
    );

    always_comb begin
        result_d.valid = size_ok & run_ok;
        result_d.mask  = result_d.valid ? tiled : '0;
    end

    assign mask_o  = result_d.mask;
    assign valid_o = result_d.valid;
endmodule

// File: rtl/bmask_decoder_chk.sv
module bmask_decoder_chk (
    input logic        wide_i,
    input logic [5:0]  run_code_i,
    input logic [5:0]  rot_code_i,
    input logic [63:0] mask_o,
    input logic        valid_o
);
    int e_w;
    int s_v;

    always_comb begin
        casez ({wide_i, run_code_i})
            7'b1??????: e_w = 64;
            7'b00?????: e_w = 32;
            7'b010????: e_w = 16;
            7'b0110???: e_w = 8;
            7'b01110??: e_w = 4;
            7'b011110?: e_w = 2;
            default:    e_w = 0;
        endcase
        s_v = (e_w == 0) ? 0 : (int'(run_code_i) % e_w);
    end

    always_comb begin
        p_no_size_r2: assert (!(!wide_i && run_code_i[5:1] == 5'b11111) || !valid_o);
        p_run_full_r3: assert (!(e_w != 0 && s_v == e_w - 1) || !valid_o);
        p_zero_when_bad_r7: assert (valid_o || mask_o == 64'd0);
        p_not_flat_r8: assert (!valid_o || (mask_o != 64'd0 && mask_o != '1));
        p_popcount_r8: assert (!valid_o || e_w == 0 ||
                               $countones(mask_o) == (s_v + 1) * (64 / e_w));
        p_base_bit_r4: assert (!valid_o || rot_code_i != 6'd0 || mask_o[0]);
    end
endmodule

bind bmask_decoder bmask_decoder_chk u_chk (
    .wide_i     (wide_i),
    .run_code_i (run_code_i),
    .rot_code_i (rot_code_i),
    .mask_o     (mask_o),
    .valid_o    (valid_o)
);

// File: tb/bmask_decoder_tb.sv
module bmask_decoder_tb;
    logic        clk = 1'b0;
    logic        wide;
    logic [5:0]  run_code;
    logic [5:0]  rot_code;
    logic [63:0] mask;
    logic        valid;
    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    bmask_decoder u_dut (
        .wide_i     (wide),
        .run_code_i (run_code),
        .rot_code_i (rot_code),
        .mask_o     (mask),
        .valid_o    (valid)
    );

    function automatic void model(input logic w, input logic [5:0] rc,
                                  input logic [5:0] ro,
                                  output logic [63:0] m, output logic v);
        int e;
        int s;
        int r;
        logic [63:0] el;
        e = 0;
        if (w) e = 64;
        else if (!rc[5]) e = 32;
        else if (!rc[4]) e = 16;
        else if (!rc[3]) e = 8;
        else if (!rc[2]) e = 4;
        else if (!rc[1]) e = 2;
        m = '0;
        v = 1'b0;
        if (e == 0) return;
        s = int'(rc) % e;
        r = int'(ro) % e;
        if (s == e - 1) return;
        v  = 1'b1;
        el = '0;
        for (int k = 0; k <= s; k++) el[(k - r + e) % e] = 1'b1;
        for (int j = 0; j < 64; j++) m[j] = el[j % e];
    endfunction

    task automatic apply(input logic w, input logic [5:0] rc, input logic [5:0] ro);
        @(posedge clk);
        wide = w; run_code = rc; rot_code = ro;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_first_state;
        apply(1'b1, 6'd0, 6'd0);
        check("R4 single bit", mask, 64'h1);
        check("R4 valid", {63'd0, valid}, 64'd1);
        apply(1'b1, 6'd62, 6'd0);
        check("R4 long run", mask, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_sizes;
        apply(1'b0, 6'b000000, 6'd0);
        check("R1 e32", mask, 64'h0000_0001_0000_0001);
        apply(1'b0, 6'b111100, 6'd0);
        check("R1 e2", mask, 64'h5555_5555_5555_5555);
        apply(1'b0, 6'b110000, 6'd1);
        check("R1 e8 R5", mask, 64'h8080_8080_8080_8080);
    endtask

    task automatic t_rotation;
        apply(1'b0, 6'b111100, 6'd1);
        check("R5 e2 rot", mask, 64'hAAAA_AAAA_AAAA_AAAA);
        apply(1'b0, 6'b100111, 6'd4);
        check("R5 e16 wrap", mask, 64'hF00F_F00F_F00F_F00F);
        apply(1'b1, 6'd0, 6'd1);
        check("R5 e64 wrap", mask, 64'h8000_0000_0000_0000);
        apply(1'b0, 6'b111000, 6'd63);
        check("R5 R6 e4 high rot", mask, 64'h2222_2222_2222_2222);
    endtask

    task automatic t_reserved;
        apply(1'b0, 6'b111110, 6'd5);
        check("R2 valid", {63'd0, valid}, 64'd0);
        check("R7 mask", mask, 64'd0);
        apply(1'b0, 6'b111111, 6'd0);
        check("R2 valid", {63'd0, valid}, 64'd0);
        apply(1'b1, 6'd63, 6'd3);
        check("R3 e64 valid", {63'd0, valid}, 64'd0);
        check("R7 e64 mask", mask, 64'd0);
        apply(1'b0, 6'b011111, 6'd0);
        check("R3 e32 valid", {63'd0, valid}, 64'd0);
        apply(1'b0, 6'b111101, 6'd0);
        check("R3 e2 valid", {63'd0, valid}, 64'd0);
    endtask

    task automatic t_exhaustive;
        logic [63:0] em;
        logic        ev;
        for (int idx = 0; idx < 8192; idx++) begin
            apply(idx[12], idx[11:6], idx[5:0]);
            model(idx[12], idx[11:6], idx[5:0], em, ev);
            check("R6 R8 sweep", {mask[62:0], valid} ^ {63'd0, 1'b0} ^
                  {mask[63], 63'd0} ^ {mask[63], 63'd0},
                  {em[62:0], ev});
            if (mask[63] !== em[63]) begin
                n_fails++;
                $display("FAIL R6 sweep top bit: actual %b expected %b", mask[63], em[63]);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        wide = 1'b0; run_code = '0; rot_code = '0;
        t_first_state();
        t_sizes();
        t_rotation();
        t_reserved();
        t_exhaustive();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule